// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup with Fault Reporting

This block turns a 32-bit virtual address into a physical page frame by searching one of two small 4-way translation tables: one serves instruction fetches, the other serves loads and stores. Pages are 8 KB. Each table has 16 rows, and each row holds one entry per way. An entry is a pair of 32-bit words: a tag word with the page number and the owning address-space ID, and an attribute word with the frame number and the global, valid, kernel, write and execute flags. The lookup matches the page number and either the address-space ID or the global flag. It then applies up to four protection checks in a fixed order. On success it returns the frame and the granted rights. Otherwise it returns a fault vector.

A request is offered on a valid/ready handshake. It carries the address, the access kind, a user-mode flag, a debug flag, the current address-space ID and four check-enable bits. Requests are accepted when the response slot is empty or is being drained in the same cycle. The result appears on the response channel one cycle after acceptance and stays there until the consumer takes it. On every fault that is not a debug access, the block updates two software-facing registers that a refill handler reads: a selection word naming the row and way to refill, and a cause word describing the failed access. It also advances a 16-bit pseudo-random sequence, which picks the way to replace on a miss. Table entries are loaded through a separate single-cycle write port.

Top module: `tlb_xlate_unit`

## Requirements
- R1: The row is address bits 16:13. A way hits when tag bits 31:13 equal address bits 31:13, and either attribute bit 4 (global) is set or tag bits 7:0 equal `cur_pid`.
- R2: When several ways of the row hit, the lowest-numbered way is used. The response frame is attribute bits 31:13 of that entry.
- R3: Access kind 2 (execute) searches the instruction table, whose vector base is 4. Kinds 0 (read), 1 (write) and 3 search the data table, whose vector base is 8. A miss faults with vector base+0.
- R4: `chk_en` bit 3 enables the write check, bit 2 the kernel check, bit 1 the execute check and bit 0 the valid check. On a hit the checks are applied in this order, and the first that applies faults the access:
  - kernel: enabled, attribute bit 2 set and `req_user` high, giving base+2;
  - write: kind 1 with attribute bit 1 clear, giving base+3;
  - execute: kind 2 with attribute bit 0 clear, giving base+3;
  - invalid: attribute bit 3 clear, giving base+1.
- R5: A successful response grants the rights in `rsp_perm`. Bit 0 (read) is always set. Bit 1 (write) is set when attribute bit 1 is set. Bit 2 (execute) is set only for the instruction table, and only when either `chk_en` bit 1 or attribute bit 0 is set. `rsp_vec` is 0 on success.
- R6: The replacement sequence is 16 bits and resets to 0xCCCC. A step shifts it right by one and puts into bit 15 the parity of the state ANDed with 0x8805. It steps exactly once per accepted non-debug fault and at no other time.
- R7: On a non-debug fault, `sel_reg` is loaded with the row in bits 3:0 and a way in bits 5:4, all other bits zero. The way is the hitting way for a protection fault and sequence bits 1:0 taken before the step for a miss. The register resets to 0.
- R8: On a non-debug fault, `cause_reg` is loaded with address bits 31:13 in bits 31:13, an access code in bits 9:8 and `cur_pid` in bits 7:0, all other bits zero. The access code is 0 for read, 1 for write, 2 for execute, and 0 for kind 3. The register resets to 0.
- R9: A debug access produces a normal response but leaves `sel_reg`, `cause_reg` and the replacement sequence unchanged.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge is presented on the response outputs after that edge. The response holds steady while `rsp_valid` is high and `rsp_ready` is low. After reset `req_ready` is 1 and `rsp_valid` is 0.
- R11: Reset clears every entry of both tables to zero. `wr_en` writes `wr_hi`/`wr_lo` into the table chosen by `wr_itlb` (1 = instruction), at way `wr_way` and row `wr_row`. The write is seen by requests accepted after the write edge.
- R12: On any fault `rsp_perm` is 0. On a miss `rsp_pfn` is 0. On a protection fault `rsp_pfn` carries the matched entry's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 treated as read |
| req_user | input | 1 | Access made in user mode |
| req_debug | input | 1 | Debug access; no register or sequence update |
| cur_pid | input | 8 | Current address-space ID |
| chk_en | input | 4 | Check enables: 3 write, 2 kernel, 1 execute, 0 valid |
| wr_en | input | 1 | Entry write strobe |
| wr_itlb | input | 1 | Write targets the instruction table |
| wr_way | input | 2 | Way written |
| wr_row | input | 4 | Row written |
| wr_hi | input | 32 | Tag word to store |
| wr_lo | input | 32 | Attribute word to store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Access faulted |
| rsp_vec | output | 4 | Fault vector, 0 on success |
| rsp_pfn | output | 19 | Physical frame number |
| rsp_perm | output | 3 | Granted rights: 2 execute, 1 write, 0 read |
| sel_reg | output | 32 | Refill selection word |
| cause_reg | output | 32 | Fault cause word |

## Verification
The hardest case to reach is a protection fault, where the selection word must name the hitting way instead of the pseudo-random one. A single stimulus has to produce a hit and also trip the intended check while suppressing the checks ranked above it. The bench therefore loads entries whose flag combinations overlap (kernel with write, kernel with invalid) and toggles the user flag and individual check enables between otherwise identical requests. A debug miss placed just before an ordinary miss shows through the reported refill way that the sequence did not move. A long run of misses exposes the sequence itself one way value at a time.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  // Attribute word flag positions (decoded by the refill handler as well)
  localparam int LO_GLOBAL = 4;
  localparam int LO_VALID  = 3;
  localparam int LO_KERNEL = 2;
  localparam int LO_WRITE  = 1;
  localparam int LO_EXEC   = 0;

  // Check-enable positions inside chk_en
  localparam int CHK_WRITE  = 3;
  localparam int CHK_KERNEL = 2;
  localparam int CHK_EXEC   = 1;
  localparam int CHK_VALID  = 0;

  // Granted-rights positions
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  localparam int VEC_W = 4;
  localparam logic [VEC_W-1:0] VEC_BASE_INSN = 4'd4;
  localparam logic [VEC_W-1:0] VEC_BASE_DATA = 4'd8;

  localparam logic [1:0] OFF_MISS   = 2'd0;
  localparam logic [1:0] OFF_INVAL  = 2'd1;
  localparam logic [1:0] OFF_KERNEL = 2'd2;
  localparam logic [1:0] OFF_RIGHTS = 2'd3;

  // Cause word access-code field
  localparam int CAUSE_CODE_LSB = 8;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENT_W   = 32,
  parameter int NUM_TLB = 2,
  parameter int WAYS    = 4,
  parameter int ROWS    = 16,
  localparam int TLB_W  = (NUM_TLB > 1) ? $clog2(NUM_TLB) : 1,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [TLB_W-1:0]            wr_tlb,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [ROW_W-1:0]            wr_row,
  input  logic [ENT_W-1:0]            wr_hi,
  input  logic [ENT_W-1:0]            wr_lo,
  input  logic [TLB_W-1:0]            rd_tlb,
  input  logic [ROW_W-1:0]            rd_row,
  output logic [WAYS-1:0][ENT_W-1:0]  rd_hi,
  output logic [WAYS-1:0][ENT_W-1:0]  rd_lo
);

  logic [NUM_TLB-1:0][WAYS-1:0][ENT_W-1:0] row_hi;
  logic [NUM_TLB-1:0][WAYS-1:0][ENT_W-1:0] row_lo;

  for (genvar t = 0; t < NUM_TLB; t++) begin : g_tlb
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam logic [TLB_W-1:0] T_ID = TLB_W'(t);
      localparam logic [WAY_W-1:0] W_ID = WAY_W'(w);

      logic [ENT_W-1:0] hi_q [ROWS];
      logic [ENT_W-1:0] lo_q [ROWS];
      logic             wr_here;

      assign wr_here = wr_en && (wr_tlb == T_ID) && (wr_way == W_ID);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int r = 0; r < ROWS; r++) begin
            hi_q[r] <= '0;
            lo_q[r] <= '0;
          end
        end else if (wr_here) begin
          hi_q[wr_row] <= wr_hi;
          lo_q[wr_row] <= wr_lo;
        end
      end

      assign row_hi[t][w] = hi_q[rd_row];
      assign row_lo[t][w] = lo_q[rd_row];
    end
  end

  assign rd_hi = row_hi[rd_tlb];
  assign rd_lo = row_lo[rd_tlb];

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_xlate_pkg::*;
#(
  parameter int ENT_W     = 32,
  parameter int WAYS      = 4,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8,
  localparam int VPN_W    = ENT_W - PAGE_BITS,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0][ENT_W-1:0]  set_hi,
  input  logic [WAYS-1:0][ENT_W-1:0]  set_lo,
  input  logic [VPN_W-1:0]            req_vpn,
  input  logic [PID_W-1:0]            req_pid,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [ENT_W-1:0]            hit_lo
);

  logic [WAYS-1:0] way_hit;
  logic [WAYS-1:0] unused_tag_bits;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic tag_eq, owner_ok;
    assign tag_eq   = (set_hi[w][ENT_W-1:PAGE_BITS] == req_vpn);
    assign owner_ok = set_lo[w][LO_GLOBAL] || (set_hi[w][PID_W-1:0] == req_pid);
    assign way_hit[w] = tag_eq && owner_ok;
    assign unused_tag_bits[w] = ^set_hi[w][PAGE_BITS-1:PID_W];
  end

  // Lowest-numbered hitting way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit    = |way_hit;
  assign hit_lo = set_lo[hit_way];

  AST_WAY_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> way_hit[hit_way]); // R2

  AST_NO_HIT_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_way == '0)); // R1

endmodule

// File: rtl/tlb_refill_lfsr.sv
module tlb_refill_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'h8805,
  parameter logic [W-1:0] SEED = 16'hCCCC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);

  logic feedback;
  assign feedback = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {feedback, state[W-1:1]};
  end

  AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state)); // R6

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R6

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
  import tlb_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int ROWS      = 16,
  parameter int WAYS      = 4,
  parameter int PID_W     = 8,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int NUM_TLB  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic              req_debug,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic [3:0]        chk_en,
  input  logic              wr_en,
  input  logic              wr_itlb,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [VA_W-1:0]   wr_hi,
  input  logic [VA_W-1:0]   wr_lo,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [VEC_W-1:0]  rsp_vec,
  output logic [VPN_W-1:0]  rsp_pfn,
  output logic [2:0]        rsp_perm,
  output logic [VA_W-1:0]   sel_reg,
  output logic [VA_W-1:0]   cause_reg
);

  acc_kind_e kind;
  assign kind = acc_kind_e'(req_kind);

  logic [VPN_W-1:0] req_vpn;
  logic [ROW_W-1:0] req_row;
  logic             use_insn;

  assign req_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
  assign req_row  = req_vpn[ROW_W-1:0];
  assign use_insn = (kind == ACC_EXEC);

  // Table storage: index 1 is the instruction table, index 0 the data table
  logic [WAYS-1:0][VA_W-1:0] set_hi, set_lo;

  tlb_entry_store #(
    .ENT_W(VA_W), .NUM_TLB(NUM_TLB), .WAYS(WAYS), .ROWS(ROWS)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_tlb(wr_itlb), .wr_way(wr_way), .wr_row(wr_row),
    .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rd_tlb(use_insn), .rd_row(req_row),
    .rd_hi(set_hi), .rd_lo(set_lo)
  );

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [VA_W-1:0]  hit_lo;

  tlb_way_match #(
    .ENT_W(VA_W), .WAYS(WAYS), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n),
    .set_hi(set_hi), .set_lo(set_lo),
    .req_vpn(req_vpn), .req_pid(cur_pid),
    .hit(hit), .hit_way(hit_way), .hit_lo(hit_lo)
  );

  logic              accept, log_fault;
  logic [LFSR_W-1:0] rnd;

  tlb_refill_lfsr #(
    .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(log_fault), .state(rnd)
  );

  // Fault ranking: kernel, then write/exec rights, then invalid
  logic             fault_c;
  logic [1:0]       off_c;
  logic [2:0]       perm_c;
  logic [VEC_W-1:0] base_c, vec_c;
  logic [1:0]       code_c;

  always_comb begin
    fault_c = 1'b1;
    off_c   = OFF_MISS;
    perm_c  = '0;
    if (hit) begin
      fault_c = 1'b0;
      if (chk_en[CHK_KERNEL] && hit_lo[LO_KERNEL] && req_user) begin
        fault_c = 1'b1;
        off_c   = OFF_KERNEL;
      end else if (kind == ACC_WRITE && chk_en[CHK_WRITE] && !hit_lo[LO_WRITE]) begin
        fault_c = 1'b1;
        off_c   = OFF_RIGHTS;
      end else if (kind == ACC_EXEC && chk_en[CHK_EXEC] && !hit_lo[LO_EXEC]) begin
        fault_c = 1'b1;
        off_c   = OFF_RIGHTS;
      end else if (chk_en[CHK_VALID] && !hit_lo[LO_VALID]) begin
        fault_c = 1'b1;
        off_c   = OFF_INVAL;
      end
      if (!fault_c) begin
        perm_c[PERM_R] = 1'b1;
        perm_c[PERM_W] = hit_lo[LO_WRITE];
        perm_c[PERM_X] = use_insn && (chk_en[CHK_EXEC] || hit_lo[LO_EXEC]);
      end
    end
  end

  assign base_c = use_insn ? VEC_BASE_INSN : VEC_BASE_DATA;
  assign vec_c  = fault_c ? (base_c + {{(VEC_W-2){1'b0}}, off_c}) : '0;

  always_comb begin
    unique case (kind)
      ACC_WRITE: code_c = 2'd1;
      ACC_EXEC:  code_c = 2'd2;
      default:   code_c = 2'd0;
    endcase
  end

  // Refill hints for the handler
  logic [WAY_W-1:0] way_pick;
  logic [VA_W-1:0]  sel_next, cause_next;

  assign way_pick = hit ? hit_way : rnd[WAY_W-1:0];

  always_comb begin
    sel_next = '0;
    sel_next[ROW_W-1:0]           = req_row;
    sel_next[ROW_W+WAY_W-1:ROW_W] = way_pick;
    cause_next = '0;
    cause_next[VA_W-1:PAGE_BITS]               = req_vpn;
    cause_next[CAUSE_CODE_LSB+1:CAUSE_CODE_LSB] = code_c;
    cause_next[PID_W-1:0]                      = cur_pid;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign log_fault = accept && fault_c && !req_debug;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault_c;
      rsp_vec   <= vec_c;
      rsp_pfn   <= hit ? hit_lo[VA_W-1:PAGE_BITS] : '0;
      rsp_perm  <= perm_c;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_reg   <= '0;
      cause_reg <= '0;
    end else if (log_fault) begin
      sel_reg   <= sel_next;
      cause_reg <= cause_next;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{req_vaddr[PAGE_BITS-1:0], hit_lo[PAGE_BITS-1:LO_GLOBAL+1],
                         rnd[LFSR_W-1:WAY_W]};

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) &&
                                   $stable(rsp_vec) && $stable(rsp_pfn) &&
                                   $stable(rsp_perm))); // R10

  AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_debug) |=> ($stable(sel_reg) && $stable(cause_reg))); // R9

  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000)); // R12

  AST_OK_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_perm[PERM_R] && rsp_vec == '0)); // R5

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_vec >= 4'd4 && rsp_vec <= 4'd11)); // R3

endmodule

// File: tb/tlb_xlate_unit_tb.sv
module tlb_xlate_unit_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0, req_debug = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic [3:0]  chk_en = '0;
  logic        wr_en = 1'b0, wr_itlb = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_row = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_fault;
  logic [3:0]  rsp_vec;
  logic [18:0] rsp_pfn;
  logic [2:0]  rsp_perm;
  logic [31:0] sel_reg, cause_reg;

  tlb_xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .req_debug(req_debug),
    .cur_pid(cur_pid), .chk_en(chk_en),
    .wr_en(wr_en), .wr_itlb(wr_itlb), .wr_way(wr_way), .wr_row(wr_row),
    .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_vec(rsp_vec), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
    .sel_reg(sel_reg), .cause_reg(cause_reg)
  );

  typedef struct packed {
    logic        fault;
    logic [3:0]  vec;
    logic [18:0] pfn;
    logic [2:0]  perm;
    logic [31:0] sel;
    logic [31:0] cause;
  } exp_t;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  exp_t  expq[$];
  string tagq[$];

  // Reference state built from the requirements
  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  logic [15:0] m_lfsr;
  logic [31:0] m_sel, m_cause;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hi(logic [18:0] vpn, logic [7:0] pid);
    return {vpn, 5'b0, pid};
  endfunction

  function automatic logic [31:0] mk_lo(logic [18:0] pfn, bit g, bit v, bit k, bit w, bit x);
    return {pfn, 8'b0, g, v, k, w, x};
  endfunction

  function automatic logic [31:0] va_of(logic [18:0] vpn);
    return {vpn, 13'h0A4};
  endfunction

  task automatic wr_entry(bit itlb, int way, int row, logic [31:0] hi, logic [31:0] lo);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_itlb = itlb; wr_way = 2'(way); wr_row = 4'(row);
    wr_hi = hi; wr_lo = lo;
    @(posedge clk); #1;
    wr_en = 1'b0;
    m_hi[itlb ? 1 : 0][way][row] = hi;
    m_lo[itlb ? 1 : 0][way][row] = lo;
  endtask

  task automatic request(string tag, logic [31:0] va, logic [1:0] kind, bit user,
                         bit dbg, logic [7:0] pid, logic [3:0] cfg);
    exp_t        e;
    logic [18:0] vpn;
    logic [3:0]  row;
    int          t, hw;
    bit          hit;
    logic [31:0] lo;
    logic [1:0]  off, code;
    logic [3:0]  base;
    vpn = va[31:13];
    row = vpn[3:0];
    t   = (kind == 2'd2) ? 1 : 0;
    hit = 0; hw = 0; lo = '0;
    for (int w = 0; w < 4; w++) begin
      if (!hit && m_hi[t][w][row][31:13] == vpn &&
          (m_lo[t][w][row][4] || m_hi[t][w][row][7:0] == pid)) begin
        hit = 1; hw = w; lo = m_lo[t][w][row];
      end
    end
    base = (t == 1) ? 4'd4 : 4'd8;
    e = '0;
    off = 2'd0;
    if (hit) begin
      e.pfn = lo[31:13];
      if (cfg[2] && lo[2] && user)                 begin e.fault = 1; off = 2'd2; end
      else if (kind == 2'd1 && cfg[3] && !lo[1])   begin e.fault = 1; off = 2'd3; end
      else if (kind == 2'd2 && cfg[1] && !lo[0])   begin e.fault = 1; off = 2'd3; end
      else if (cfg[0] && !lo[3])                   begin e.fault = 1; off = 2'd1; end
      if (!e.fault) e.perm = {(t == 1) && (cfg[1] || lo[0]), lo[1], 1'b1};
    end else begin
      e.fault = 1;
    end
    e.vec = e.fault ? base + {2'b0, off} : 4'd0;
    code = (kind == 2'd1) ? 2'd1 : (kind == 2'd2) ? 2'd2 : 2'd0;
    if (e.fault && !dbg) begin
      m_sel   = {26'b0, hit ? 2'(hw) : m_lfsr[1:0], row};
      m_cause = {vpn, 3'b0, code, pid};
      m_lfsr  = {^(m_lfsr & 16'h8805), m_lfsr[15:1]};
    end
    e.sel   = m_sel;
    e.cause = m_cause;
    expq.push_back(e);
    tagq.push_back(tag);

    @(posedge clk); #1;
    req_vaddr = va; req_kind = kind; req_user = user; req_debug = dbg;
    cur_pid = pid; chk_en = cfg; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor: compare every delivered response against the scoreboard
  exp_t  mon_e;
  string mon_t;
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected response: actual=1 expected=0");
      end else begin
        mon_e = expq.pop_front();
        mon_t = tagq.pop_front();
        chk(mon_t, "fault", 32'(rsp_fault), 32'(mon_e.fault));
        chk(mon_t, "vec",   32'(rsp_vec),   32'(mon_e.vec));
        chk(mon_t, "pfn",   32'(rsp_pfn),   32'(mon_e.pfn));
        chk(mon_t, "perm",  32'(rsp_perm),  32'(mon_e.perm));
        chk(mon_t, "sel",   sel_reg,        mon_e.sel);
        chk(mon_t, "cause", cause_reg,      mon_e.cause);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 4; w++)
        for (int r = 0; r < 16; r++) begin
          m_hi[t][w][r] = '0;
          m_lo[t][w][r] = '0;
        end
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset req_ready", 32'(req_ready), 32'd1);
    chk("R10", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R7",  "reset sel_reg",   sel_reg,   32'd0);
    chk("R8",  "reset cause_reg", cause_reg, 32'd0);

    // R11: cleared entries match page 0 with PID 0
    request("R11", 32'h0000_0010, 2'd0, 0, 0, 8'h00, 4'h0);
    // R4 invalid on a cleared entry; protection fault names the hit way (R7)
    request("R4",  32'h0000_0010, 2'd0, 0, 0, 8'h00, 4'hF);

    // R1: PID match in way 2 of row 5
    wr_entry(0, 2, 5, mk_hi(19'h12345, 8'h21), mk_lo(19'h0ABCD, 0, 1, 0, 1, 0));
    request("R1", va_of(19'h12345), 2'd0, 0, 0, 8'h21, 4'hF);
    request("R1", va_of(19'h12345), 2'd0, 0, 0, 8'h22, 4'hF);   // PID mismatch: miss
    // R1: global entry ignores PID
    wr_entry(0, 1, 5, mk_hi(19'h00775, 8'h99), mk_lo(19'h11111, 1, 1, 0, 1, 0));
    request("R1", va_of(19'h00775), 2'd1, 1, 0, 8'h05, 4'hF);

    // R2: two hitting ways, lowest wins
    wr_entry(0, 3, 7, mk_hi(19'h40007, 8'h21), mk_lo(19'h00B00, 0, 1, 0, 0, 0));
    wr_entry(0, 0, 7, mk_hi(19'h40007, 8'h21), mk_lo(19'h00A00, 0, 1, 0, 0, 0));
    request("R2", va_of(19'h40007), 2'd0, 0, 0, 8'h21, 4'hF);

    // R4: kernel beats write, then write alone, then checks disabled
    wr_entry(0, 0, 9, mk_hi(19'h00009, 8'h21), mk_lo(19'h00123, 0, 1, 1, 0, 0));
    request("R4", va_of(19'h00009), 2'd1, 1, 0, 8'h21, 4'hF);
    request("R4", va_of(19'h00009), 2'd1, 0, 0, 8'h21, 4'hF);
    request("R5", va_of(19'h00009), 2'd0, 0, 0, 8'h21, 4'hF);
    request("R4", va_of(19'h00009), 2'd0, 1, 0, 8'h21, 4'hB);
    // R4: kernel beats invalid; invalid alone names way 3 (R7)
    wr_entry(0, 3, 10, mk_hi(19'h1000A, 8'h21), mk_lo(19'h00456, 0, 0, 1, 1, 0));
    request("R4", va_of(19'h1000A), 2'd0, 1, 0, 8'h21, 4'hF);
    request("R7", va_of(19'h1000A), 2'd0, 0, 0, 8'h21, 4'hF);

    // R3/R5: instruction table
    wr_entry(1, 1, 3, mk_hi(19'h20003, 8'h21), mk_lo(19'h00007, 0, 1, 0, 0, 1));
    request("R5", va_of(19'h20003), 2'd2, 0, 0, 8'h21, 4'hF);
    request("R3", va_of(19'h20003), 2'd0, 0, 0, 8'h21, 4'hF);   // data table misses
    wr_entry(1, 2, 4, mk_hi(19'h20004, 8'h21), mk_lo(19'h00008, 0, 1, 0, 1, 0));
    request("R4", va_of(19'h20004), 2'd2, 0, 0, 8'h21, 4'hF);
    request("R5", va_of(19'h20004), 2'd2, 0, 0, 8'h21, 4'hD);
    request("R3", va_of(19'h3FFF3), 2'd2, 0, 0, 8'h21, 4'hF);   // exec miss, base 4

    // R8: kind 3 behaves as read
    request("R8", va_of(19'h12345), 2'd3, 0, 0, 8'h21, 4'hF);
    request("R8", va_of(19'h12345), 2'd3, 0, 0, 8'h55, 4'hF);

    // R9: debug miss leaves hints and sequence alone
    request("R9", va_of(19'h5555C), 2'd0, 0, 1, 8'h21, 4'hF);
    request("R9", va_of(19'h5555C), 2'd1, 0, 0, 8'h21, 4'hF);

    // R10: back-pressure holds the response
    @(posedge clk); #1 rsp_ready = 1'b0;
    request("R10", va_of(19'h12345), 2'd0, 0, 0, 8'h21, 4'hF);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "stall rsp_valid", 32'(rsp_valid), 32'd1);
      chk("R10", "stall req_ready", 32'(req_ready), 32'd0);
      chk("R10", "stall rsp_pfn",   32'(rsp_pfn),   32'h0ABCD);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;

    // R6: a run of misses reveals the sequence through the refill way
    for (int i = 0; i < 24; i++)
      request("R6", va_of(19'h60000 + 19'(i * 17)), 2'd0, 0, 0, 8'hE0, 4'hF);

    // R11: overwrite an entry and see the new frame
    wr_entry(0, 2, 5, mk_hi(19'h12345, 8'h21), mk_lo(19'h0FFFF, 0, 1, 0, 1, 0));
    request("R11", va_of(19'h12345), 2'd0, 0, 0, 8'h21, 4'hF);
    // R12: miss after overwrite with a foreign PID
    request("R12", va_of(19'h12345), 2'd1, 0, 0, 8'h7F, 4'hF);

    for (int i = 0; i < 50 && expq.size() != 0; i++) @(posedge clk);
    if (expq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 pending responses: actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule